// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date from a 32.768 kHz clock enable. Nine byte-wide fields are held in packed BCD: hundredths of a second, seconds, minutes, hours (24-hour), day of week, date, month, year and century. A fractional accumulator turns the 32768 enable pulses in each second into exactly 100 hundredth ticks. Each hundredth tick feeds a carry chain that handles month lengths and leap years in BCD, with no host involvement.

A host reaches the fields through a plain parallel port. A write loads one field and restarts the sub-second prescaler. A snapshot strobe copies every field into a shadow bank, and all reads come from that bank. A read that spans several bytes therefore never sees a carry partway through.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time is century 0x20, year 0x00, month 0x01, date 0x01, day 0x01, hour, minute, second and hundredths 0x00. A snapshot taken right after reset returns these values.
- R2: A hundredth tick occurs on the enable pulse at which the running sum of 100 per pulse reaches 32768 (that amount is then subtracted). After reset or a write, the first tick lands on the 328th pulse, and exactly 100 ticks occur every 32768 pulses. Fields change only on a hundredth tick or a write.
- R3: Hundredths count 0x00..0x99, and seconds and minutes count 0x00..0x59, in BCD. Each wraps to 0x00 and carries into the next field.
- R4: Hours count 0x00..0x23. Leaving 23:59:59.99 gives 00:00:00.00 and advances the date.
- R5: Day of week counts 0x01..0x07 and goes from 0x07 back to 0x01 at each midnight.
- R6: Months 0x04, 0x06, 0x09 and 0x11 end after date 0x30. All other months except February end after 0x31. The date then returns to 0x01 and the month advances in BCD (0x09 goes to 0x10).
- R7: February ends after 0x29 when the BCD year is divisible by 4 (0x00 counts as divisible), and after 0x28 otherwise.
- R8: Month 0x12 rolls to 0x01 and advances the year. Year 0x99 rolls to 0x00 and advances the century.
- R9: Write addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year, 8 century. A write loads the field on the next clock edge and leaves the other fields unchanged. It also clears the prescaler sum, and no tick counts in the write cycle.
- R10: A snapshot strobe copies all fields at the clock edge. Reads use the same address map and return the copy unchanged until the next strobe. Addresses 9 and above read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle 32.768 kHz time-base pulse |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | ADDR_W | Field address for writes |
| wr_data | input | 8 | BCD value to load |
| snap_req | input | 1 | Copy all fields into the read bank |
| rd_addr | input | ADDR_W | Field address for reads |
| rd_data | output | 8 | Field value from the read bank |

## Verification
If the prescaler sum is wrong, a hundredth tick arrives one or more pulses early or late. That shows up as a hundredths value that is off by one after 328 pulses, or a seconds field that has not moved after 32768 pulses. If the carry chain is wrong, the error appears at the first boundary tick (end of month, year or day), so a single pulse burst starting at 23:59:59.99 on the chosen date exposes it. If the shadow bank is wrong, reads change between strobes even though no new strobe was given.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int FIELD_N = 9;

   typedef logic [7:0] bcd_t;

   typedef struct packed {
      bcd_t cent;
      bcd_t year;
      bcd_t month;
      bcd_t date;
      bcd_t day;
      bcd_t hour;
      bcd_t minute;
      bcd_t second;
      bcd_t hund;
   } rtc_time_t;

   typedef logic [FIELD_N-1:0][7:0] rtc_bank_t;

   function automatic bcd_t bcd_inc(input bcd_t v);
      bcd_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   function automatic logic bcd_div4(input bcd_t y);
      logic r;
      if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      return r;
   endfunction

   function automatic bcd_t month_last(input bcd_t m, input logic leap);
      bcd_t r;
      case (m)
         8'h02:                      r = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICK_HZ = 32768,
   parameter int HUND_HZ = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic clr,
   output logic hund_tick
);

   if (HUND_HZ < 1 || TICK_HZ < HUND_HZ) begin : g_bad_rate
      $error("rtc_prescaler: TICK_HZ must be at least HUND_HZ and HUND_HZ positive");
   end

   if (TICK_HZ % HUND_HZ == 0) begin : g_int_div
      localparam int DIV = TICK_HZ / HUND_HZ;
      localparam int DW  = (DIV < 2) ? 1 : $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] cnt;

      assign hund_tick = tick_en && !clr && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cnt <= '0;
         else if (clr)       cnt <= '0;
         else if (hund_tick) cnt <= '0;
         else if (tick_en)   cnt <= cnt + DW'(1);
      end
   end else begin : g_frac_acc
      localparam int ACC_W = $clog2(TICK_HZ + HUND_HZ);
      localparam logic [ACC_W-1:0] STEP = ACC_W'(HUND_HZ);
      localparam logic [ACC_W-1:0] MODV = ACC_W'(TICK_HZ);
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] acc_sum;
      logic             reach;

      assign acc_sum   = acc + STEP;
      assign reach     = (acc_sum >= MODV);
      assign hund_tick = tick_en && !clr && reach;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       acc <= '0;
         else if (clr)     acc <= '0;
         else if (tick_en) acc <= reach ? (acc_sum - MODV) : acc_sum;
      end
   end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter logic [7:0]  RST_CENTURY = 8'h20,
   parameter logic [7:0]  RST_YEAR    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hund_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output rtc_time_t         time_q
);

   localparam rtc_time_t RST_TIME = '{cent: RST_CENTURY, year: RST_YEAR,
                                      month: 8'h01, date: 8'h01, day: 8'h01,
                                      hour: 8'h00, minute: 8'h00,
                                      second: 8'h00, hund: 8'h00};

   rtc_time_t t, t_nxt;
   rtc_bank_t wr_bank;
   bcd_t      last_date;
   logic      c_sec, c_min, c_hr, c_day, c_mon, c_yr, c_cen;

   assign t         = time_q;
   assign last_date = month_last(t.month, bcd_div4(t.year));

   assign c_sec = hund_tick && (t.hund   >= 8'h99);
   assign c_min = c_sec     && (t.second >= 8'h59);
   assign c_hr  = c_min     && (t.minute >= 8'h59);
   assign c_day = c_hr      && (t.hour   >= 8'h23);
   assign c_mon = c_day     && (t.date   >= last_date);
   assign c_yr  = c_mon     && (t.month  >= 8'h12);
   assign c_cen = c_yr      && (t.year   >= 8'h99);

   always_comb begin
      wr_bank = rtc_bank_t'(t);
      for (int k = 0; k < FIELD_N; k++) begin
         if (wr_addr == ADDR_W'(k)) wr_bank[k] = wr_data;
      end
   end

   always_comb begin
      t_nxt = t;
      if (wr_en) begin
         t_nxt = rtc_time_t'(wr_bank);
      end else if (hund_tick) begin
         t_nxt.hund = c_sec ? 8'h00 : bcd_inc(t.hund);
         if (c_sec) t_nxt.second = c_min ? 8'h00 : bcd_inc(t.second);
         if (c_min) t_nxt.minute = c_hr  ? 8'h00 : bcd_inc(t.minute);
         if (c_hr)  t_nxt.hour   = c_day ? 8'h00 : bcd_inc(t.hour);
         if (c_day) begin
            t_nxt.day  = (t.day >= 8'h07) ? 8'h01 : bcd_inc(t.day);
            t_nxt.date = c_mon ? 8'h01 : bcd_inc(t.date);
         end
         if (c_mon) t_nxt.month  = c_yr  ? 8'h01 : bcd_inc(t.month);
         if (c_yr)  t_nxt.year   = c_cen ? 8'h00 : bcd_inc(t.year);
         if (c_cen) t_nxt.cent   = (t.cent >= 8'h99) ? 8'h00 : bcd_inc(t.cent);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= RST_TIME;
      else        time_q <= t_nxt;
   end

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_req,
   input  rtc_time_t         live_t,
   input  logic [ADDR_W-1:0] rd_addr,
   output rtc_time_t         snap_t,
   output logic [7:0]        rd_data
);

   rtc_bank_t bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_t <= '0;
      else if (snap_req) snap_t <= live_t;
   end

   assign bank = rtc_bank_t'(snap_t);

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < FIELD_N; k++) begin
         if (rd_addr == ADDR_W'(k)) rd_data = bank[k];
      end
   end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int         TICK_HZ     = 32768,
   parameter int         HUND_HZ     = 100,
   parameter int         ADDR_W      = 4,
   parameter logic [7:0] RST_CENTURY = 8'h20,
   parameter logic [7:0] RST_YEAR    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              snap_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   if ((1 << ADDR_W) < FIELD_N) begin : g_bad_addr
      $error("bcd_rtc_core: ADDR_W too narrow for the field count");
   end

   logic      hund_tick;
   rtc_time_t live_t;
   rtc_time_t snap_t;

   rtc_prescaler #(.TICK_HZ(TICK_HZ), .HUND_HZ(HUND_HZ)) presc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .clr       (wr_en),
      .hund_tick (hund_tick)
   );

   rtc_time_chain #(.ADDR_W(ADDR_W), .RST_CENTURY(RST_CENTURY),
                    .RST_YEAR(RST_YEAR)) chain_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hund_tick (hund_tick),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .time_q    (live_t)
   );

   rtc_snapshot #(.ADDR_W(ADDR_W)) snap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .snap_req (snap_req),
      .live_t   (live_t),
      .rd_addr  (rd_addr),
      .snap_t   (snap_t),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              snap_req,
   input logic              hund_tick,
   input rtc_time_t         live_t,
   input rtc_time_t         snap_t
);

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snap_t));                                   // R10
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (snap_t == $past(live_t)));                          // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !hund_tick) |=> $stable(live_t));                      // R2
   AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      hund_tick |-> (tick_en && !wr_en));                               // R9
   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(1)) |=> (live_t.second == $past(wr_data))); // R9
   AST_HUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (hund_tick && !wr_en && live_t.hund == 8'h99) |=> (live_t.hund == 8'h00)); // R3
   AST_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (hund_tick && !wr_en && live_t.hour == 8'h23 && live_t.minute == 8'h59 &&
       live_t.second == 8'h59 && live_t.hund == 8'h99)
      |=> (live_t.hour == 8'h00 && live_t.minute == 8'h00));            // R4

endmodule

bind bcd_rtc_core rtc_checker #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .snap_req  (snap_req),
   .hund_tick (hund_tick),
   .live_t    (live_t),
   .snap_t    (snap_t)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;

   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          snap_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   bcd_rtc_core dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .snap_req (snap_req),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   // time word layout, byte k = field at address k:
   // {cent, year, month, date, day, hour, minute, second, hund}
   function automatic logic [71:0] tw(input logic [7:0] ce, yr, mo, da, dw,
                                      hr, mi, se, hu);
      return {ce, yr, mo, da, dw, hr, mi, se, hu};
   endfunction

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [71:0] v);
      for (int k = 0; k < 9; k++) wr(k, v[8*k +: 8]);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic snap();
      @(negedge clk);
      snap_req = 1'b1;
      @(negedge clk);
      snap_req = 1'b0;
   endtask

   task automatic expect_byte(input int a, input logic [7:0] e, input string tag);
      rd_addr = AW'(a);
      #1;
      checks++;
      if (rd_data !== e) begin
         errors++;
         $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, e);
      end
   endtask

   task automatic expect_all(input logic [71:0] e, input string tag);
      for (int k = 0; k < 9; k++) expect_byte(k, e[8*k +: 8], tag);
   endtask

   task automatic roll_check(input logic [71:0] start, input logic [71:0] e,
                             input string tag);
      load(start);
      ticks(328);
      snap();
      expect_all(e, tag);
   endtask

   task automatic t_reset();
      snap();
      expect_all(tw(8'h20,8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00,8'h00), "R1 reset");
      expect_byte(9,  8'h00, "R10 unmapped");
      expect_byte(15, 8'h00, "R10 unmapped");
   endtask

   task automatic t_prescale();
      load(tw(8'h20,8'h10,8'h05,8'h05,8'h02,8'h00,8'h00,8'h00,8'h00));
      ticks(327); snap();
      expect_byte(0, 8'h00, "R2 no tick at 327");
      ticks(1); snap();
      expect_byte(0, 8'h01, "R2 tick at 328");
      wr(0, 8'h00);
      ticks(32768); snap();
      expect_byte(1, 8'h01, "R2 one second");
      expect_byte(0, 8'h00, "R2 one second hund");
   endtask

   task automatic t_carry();
      roll_check(tw(8'h20,8'h15,8'h06,8'h10,8'h03,8'h12,8'h34,8'h59,8'h99),
                 tw(8'h20,8'h15,8'h06,8'h10,8'h03,8'h12,8'h35,8'h00,8'h00), "R3 minute carry");
      roll_check(tw(8'h20,8'h15,8'h06,8'h10,8'h03,8'h09,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h15,8'h06,8'h10,8'h03,8'h10,8'h00,8'h00,8'h00), "R3 hour carry");
      roll_check(tw(8'h20,8'h15,8'h06,8'h10,8'h03,8'h09,8'h00,8'h00,8'h09),
                 tw(8'h20,8'h15,8'h06,8'h10,8'h03,8'h09,8'h00,8'h00,8'h10), "R3 bcd digit");
   endtask

   task automatic t_midnight();
      roll_check(tw(8'h20,8'h21,8'h03,8'h15,8'h07,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h21,8'h03,8'h16,8'h01,8'h00,8'h00,8'h00,8'h00), "R4 R5 midnight");
      roll_check(tw(8'h20,8'h21,8'h03,8'h15,8'h04,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h21,8'h03,8'h16,8'h05,8'h00,8'h00,8'h00,8'h00), "R5 weekday step");
   endtask

   task automatic t_months();
      roll_check(tw(8'h20,8'h21,8'h04,8'h30,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h21,8'h05,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 april end");
      roll_check(tw(8'h20,8'h21,8'h09,8'h30,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h21,8'h10,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 september end");
      roll_check(tw(8'h20,8'h21,8'h01,8'h30,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h21,8'h01,8'h31,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 january 30");
      roll_check(tw(8'h20,8'h21,8'h01,8'h31,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h21,8'h02,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 january end");
   endtask

   task automatic t_february();
      roll_check(tw(8'h20,8'h23,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h23,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 common year");
      roll_check(tw(8'h20,8'h24,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h24,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 leap 28");
      roll_check(tw(8'h20,8'h24,8'h02,8'h29,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h24,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 leap 29");
      roll_check(tw(8'h21,8'h00,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h21,8'h00,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 year 00");
      roll_check(tw(8'h20,8'h10,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h10,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 year 10");
   endtask

   task automatic t_year();
      roll_check(tw(8'h20,8'h24,8'h12,8'h31,8'h02,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h20,8'h25,8'h01,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R8 new year");
      roll_check(tw(8'h20,8'h99,8'h12,8'h31,8'h07,8'h23,8'h59,8'h59,8'h99),
                 tw(8'h21,8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00,8'h00), "R8 new century");
   endtask

   task automatic t_write();
      load(tw(8'h20,8'h30,8'h07,8'h04,8'h05,8'h08,8'h00,8'h00,8'h50));
      ticks(200);
      wr(2, 8'h42);
      ticks(200); snap();
      expect_all(tw(8'h20,8'h30,8'h07,8'h04,8'h05,8'h08,8'h42,8'h00,8'h50), "R9 write clears prescaler");
      ticks(128); snap();
      expect_byte(0, 8'h51, "R9 tick after write");
   endtask

   task automatic t_snapshot();
      load(tw(8'h20,8'h30,8'h07,8'h04,8'h05,8'h10,8'h20,8'h30,8'h40));
      snap();
      ticks(400);
      expect_byte(0, 8'h40, "R10 frozen hund");
      expect_byte(2, 8'h20, "R10 frozen minute");
      snap();
      expect_byte(0, 8'h41, "R10 fresh copy");
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_prescale();
      t_carry();
      t_midnight();
      t_months();
      t_february();
      t_year();
      t_write();
      t_snapshot();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         finish_run();
      end
   end

endmodule